// File: doc/BRIEF.md
# One-Hot Funnel Barrel Shifter

This block shifts or rotates an n-bit word by any distance from 0 to n-1 in a single pass. Its core is a window selector. Two n-bit words, a high word and a low word, are joined into a 2n-bit value. A strictly one-hot column select then picks n contiguous bits out of that value. The core itself cannot tell a shift from a rotate. The operation follows only from what a small front-end loads into the two halves and from which column that front-end enables.

In normal use the caller gives a 2-bit operation code, a binary distance and a data word. The front-end decodes the distance into the one-hot column select and steers either the data word or zeros into each half. A direct-window path lets the caller drive both halves and the raw column select, bypassing the front-end. On this path a select vector that is not one-hot can reach the core. The core then raises an error flag and forces the output to zero. An optional output register, enabled by default, adds one cycle of latency.

WIDTH must be a power of two.

Top module: `funnel_shifter`

## Requirements
- R1: While `rstN` is low, `dataOut` and `selError` are both 0 (with the output register enabled).
- R2: With `directEn` = 1 and column j selected (`colSelIn` = 1 << j), output bit i equals bit i+j of the 2n-bit value {`hiIn`, `loIn`}, where `hiIn` occupies bits 2n-1..n.
- R3: `opCode` 2'b00 gives a logical right shift: `dataOut` = `dataIn` >> `shiftAmt`, with zeros filling from the MSB.
- R4: `opCode` 2'b01 gives a logical left shift: `dataOut` = `dataIn` << `shiftAmt`, with zeros filling from the LSB. A distance of 0 returns `dataIn` unchanged.
- R5: `opCode` 2'b10 rotates right by `shiftAmt`: output bit i = `dataIn` bit (i+k) mod n. The number of set bits is preserved.
- R6: `opCode` 2'b11 rotates left by `shiftAmt`: output bit i = `dataIn` bit (i-k) mod n. The number of set bits is preserved.
- R7: With `directEn` = 0, the decoded column select is exactly one-hot for every code and distance, so `selError` stays 0.
- R8: With `directEn` = 1 and a `colSelIn` that is not one-hot (all zeros or more than one bit set), `selError` is 1 and `dataOut` is all zeros.
- R9: With the output register enabled, a result appears on `dataOut` one clock after its inputs are sampled. In direct mode, `opCode`, `shiftAmt` and `dataIn` have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Asynchronous active-low reset |
| directEn | input | 1 | 1 = drive the window core from hiIn/loIn/colSelIn directly |
| opCode | input | 2 | 00 shift right, 01 shift left, 10 rotate right, 11 rotate left |
| shiftAmt | input | log2(WIDTH) | Binary shift or rotate distance |
| dataIn | input | WIDTH | Word to shift or rotate |
| hiIn | input | WIDTH | High half of the window source in direct mode |
| loIn | input | WIDTH | Low half of the window source in direct mode |
| colSelIn | input | WIDTH | Raw column select in direct mode |
| dataOut | output | WIDTH | Selected window |
| selError | output | 1 | Column select reaching the core was not one-hot |

## Verification
The bench builds the block with WIDTH = 8 and the output register on. With these values every combination of the four operation codes and eight distances can be swept exhaustively for several data patterns, including the wrap distance 7 and the zero distance that needs special loading for left shifts. The 8-bit width keeps hand-computed window vectors short enough to check against the 16-bit source. The registered output also brings reset behaviour and the one-cycle latency within reach of both the bench and the bound properties.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic [1:0] {
    OP_SRL = 2'b00,
    OP_SLL = 2'b01,
    OP_ROR = 2'b10,
    OP_ROL = 2'b11
  } shift_op_e;

  // strobes from control to datapath: which halves receive the data word
  typedef struct packed {
    logic hiTakesData;
    logic loTakesData;
  } load_strobe_t;

endpackage

// File: rtl/shf_ctrl.sv
module shf_ctrl #(
  parameter int WIDTH = 8,
  localparam int AW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [1:0]           opCode,
  input  logic [AW-1:0]        shiftAmt,
  output shf_pkg::load_strobe_t strobe,
  output logic [WIDTH-1:0]     colSel
);
  import shf_pkg::*;

  logic          towardMsb;
  logic [AW-1:0] negAmt;
  logic [AW-1:0] offset;
  logic          zeroAmt;

  assign zeroAmt   = (shiftAmt == '0);
  assign towardMsb = (opCode == OP_SLL) || (opCode == OP_ROL);
  // (WIDTH - k) mod WIDTH, valid because WIDTH is a power of two
  assign negAmt    = '0 - shiftAmt;
  assign offset    = towardMsb ? negAmt : shiftAmt;

  always_comb begin
    strobe = '0;
    unique case (shift_op_e'(opCode))
      OP_SRL: begin
        strobe.hiTakesData = 1'b0;
        strobe.loTakesData = 1'b1;
      end
      OP_SLL: begin
        // distance 0 selects column 0, which reads the low half
        strobe.hiTakesData = 1'b1;
        strobe.loTakesData = zeroAmt;
      end
      OP_ROR, OP_ROL: begin
        strobe.hiTakesData = 1'b1;
        strobe.loTakesData = 1'b1;
      end
      default: strobe = '0;
    endcase
  end

  for (genvar j = 0; j < WIDTH; j++) begin : g_dec
    assign colSel[j] = (offset == AW'(j));
  end

endmodule

// File: rtl/shf_window.sv
module shf_window #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] hiWord,
  input  logic [WIDTH-1:0] loWord,
  input  logic [WIDTH-1:0] colSel,
  output logic [WIDTH-1:0] winOut,
  output logic             winErr
);
  localparam int SPAN = 2 * WIDTH;

  logic [SPAN-1:0]  srcBits;
  logic [WIDTH-1:0] rawOut;
  logic             selIsOneHot;

  assign srcBits = {hiWord, loWord};

  // AND-OR column array: output bit i reads source bit i+j for the live column j
  for (genvar i = 0; i < WIDTH; i++) begin : g_row
    assign rawOut[i] = |(colSel & srcBits[i +: WIDTH]);
  end

  assign selIsOneHot = $onehot(colSel);
  assign winOut      = selIsOneHot ? rawOut : '0;
  assign winErr      = ~selIsOneHot;

endmodule

// File: rtl/shf_datapath.sv
module shf_datapath #(
  parameter int WIDTH = 8
) (
  input  logic                  directEn,
  input  shf_pkg::load_strobe_t strobe,
  input  logic [WIDTH-1:0]      ctrlSel,
  input  logic [WIDTH-1:0]      dataIn,
  input  logic [WIDTH-1:0]      hiIn,
  input  logic [WIDTH-1:0]      loIn,
  input  logic [WIDTH-1:0]      colSelIn,
  output logic [WIDTH-1:0]      winOut,
  output logic                  winErr
);
  logic [WIDTH-1:0] hiWord;
  logic [WIDTH-1:0] loWord;
  logic [WIDTH-1:0] coreSel;

  always_comb begin
    if (directEn) begin
      hiWord  = hiIn;
      loWord  = loIn;
      coreSel = colSelIn;
    end else begin
      hiWord  = strobe.hiTakesData ? dataIn : '0;
      loWord  = strobe.loTakesData ? dataIn : '0;
      coreSel = ctrlSel;
    end
  end

  shf_window #(.WIDTH(WIDTH)) u_window (
    .hiWord (hiWord),
    .loWord (loWord),
    .colSel (coreSel),
    .winOut (winOut),
    .winErr (winErr)
  );

endmodule

// File: rtl/shf_outstage.sv
module shf_outstage #(
  parameter int WIDTH   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] winOut,
  input  logic             winErr,
  output logic [WIDTH-1:0] dataOut,
  output logic             selError
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dataOut  <= '0;
        selError <= 1'b0;
      end else begin
        dataOut  <= winOut;
        selError <= winErr;
      end
    end
  end else begin : g_comb
    assign dataOut  = winOut;
    assign selError = winErr;
  end

endmodule

// File: rtl/funnel_shifter.sv
module funnel_shifter #(
  parameter int WIDTH   = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int AW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             directEn,
  input  logic [1:0]       opCode,
  input  logic [AW-1:0]    shiftAmt,
  input  logic [WIDTH-1:0] dataIn,
  input  logic [WIDTH-1:0] hiIn,
  input  logic [WIDTH-1:0] loIn,
  input  logic [WIDTH-1:0] colSelIn,
  output logic [WIDTH-1:0] dataOut,
  output logic             selError
);
  shf_pkg::load_strobe_t strobe;
  logic [WIDTH-1:0]      ctrlSel;
  logic [WIDTH-1:0]      winOut;
  logic                  winErr;

  shf_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .opCode   (opCode),
    .shiftAmt (shiftAmt),
    .strobe   (strobe),
    .colSel   (ctrlSel)
  );

  shf_datapath #(.WIDTH(WIDTH)) u_dp (
    .directEn (directEn),
    .strobe   (strobe),
    .ctrlSel  (ctrlSel),
    .dataIn   (dataIn),
    .hiIn     (hiIn),
    .loIn     (loIn),
    .colSelIn (colSelIn),
    .winOut   (winOut),
    .winErr   (winErr)
  );

  shf_outstage #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_out (
    .clk      (clk),
    .rstN     (rstN),
    .winOut   (winOut),
    .winErr   (winErr),
    .dataOut  (dataOut),
    .selError (selError)
  );

endmodule

// File: rtl/funnel_shifter_chk.sv
module funnel_shifter_chk #(
  parameter int WIDTH   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rstN,
  input logic             directEn,
  input logic [1:0]       opCode,
  input logic [WIDTH-1:0] dataIn,
  input logic [WIDTH-1:0] ctrlSel,
  input logic [WIDTH-1:0] winOut,
  input logic             winErr,
  input logic [WIDTH-1:0] dataOut,
  input logic             selError
);

  p_ctrl_onehot_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(ctrlSel));

  p_no_err_decoded_r7: assert property (@(posedge clk) disable iff (!rstN)
    !directEn |-> !winErr);

  p_err_zero_out_r8: assert property (@(posedge clk) disable iff (!rstN)
    selError |-> (dataOut == '0));

  if (REG_OUT) begin : g_seq
    p_one_cycle_r9: assert property (@(posedge clk) disable iff (!rstN)
      $past(rstN) |-> (dataOut == $past(winOut) && selError == $past(winErr)));

    p_rot_ones_r5: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && $past(!directEn && opCode[1]))
        |-> ($countones(dataOut) == $countones($past(dataIn))));
  end else begin : g_comb
    p_rot_ones_r6: assert property (@(posedge clk) disable iff (!rstN)
      (!directEn && opCode[1]) |-> ($countones(dataOut) == $countones(dataIn)));
  end

endmodule

bind funnel_shifter funnel_shifter_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .directEn (directEn),
  .opCode   (opCode),
  .dataIn   (dataIn),
  .ctrlSel  (ctrlSel),
  .winOut   (winOut),
  .winErr   (winErr),
  .dataOut  (dataOut),
  .selError (selError)
);

// File: tb/tb_funnel_shifter.sv
module tb_funnel_shifter;
  localparam int W  = 8;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          directEn = 1'b0;
  logic [1:0]    opCode = 2'b00;
  logic [AW-1:0] shiftAmt = '0;
  logic [W-1:0]  dataIn = '0;
  logic [W-1:0]  hiIn = '0;
  logic [W-1:0]  loIn = '0;
  logic [W-1:0]  colSelIn = 8'h01;
  logic [W-1:0]  dataOut;
  logic          selError;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  funnel_shifter #(.WIDTH(W), .REG_OUT(1'b1)) dut (
    .clk(clk), .rstN(rstN), .directEn(directEn), .opCode(opCode),
    .shiftAmt(shiftAmt), .dataIn(dataIn), .hiIn(hiIn), .loIn(loIn),
    .colSelIn(colSelIn), .dataOut(dataOut), .selError(selError)
  );

  // {opCode, distance, data, expected}
  localparam int NV = 14;
  localparam logic [20:0] VEC [NV] = '{
    {2'b00, 3'd0, 8'hB5, 8'hB5},
    {2'b00, 3'd1, 8'hB5, 8'h5A},
    {2'b00, 3'd3, 8'hB5, 8'h16},
    {2'b00, 3'd7, 8'h81, 8'h01},
    {2'b01, 3'd0, 8'hB5, 8'hB5},
    {2'b01, 3'd1, 8'hB5, 8'h6A},
    {2'b01, 3'd4, 8'hB5, 8'h50},
    {2'b01, 3'd7, 8'h81, 8'h80},
    {2'b10, 3'd1, 8'hB5, 8'hDA},
    {2'b10, 3'd4, 8'hB5, 8'h5B},
    {2'b10, 3'd7, 8'h81, 8'h03},
    {2'b11, 3'd0, 8'hB5, 8'hB5},
    {2'b11, 3'd1, 8'hB5, 8'h6B},
    {2'b11, 3'd3, 8'hB5, 8'hAD}
  };

  function automatic logic [W-1:0] model(input logic [1:0] op, input int k,
                                         input logic [W-1:0] d);
    logic [W-1:0] r;
    r = '0;
    for (int i = 0; i < W; i++) begin
      case (op)
        2'b00: r[i] = (i + k < W) ? d[i + k] : 1'b0;
        2'b01: r[i] = (i - k >= 0) ? d[i - k] : 1'b0;
        2'b10: r[i] = d[(i + k) % W];
        default: r[i] = d[(i - k + W) % W];
      endcase
    end
    return r;
  endfunction

  function automatic string reqOf(input logic [1:0] op);
    case (op)
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkBit(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // apply at a falling edge, capture on the next rising edge, sample at the falling edge after
  task automatic stepOp(input logic [1:0] op, input logic [AW-1:0] k, input logic [W-1:0] d);
    directEn = 1'b0; opCode = op; shiftAmt = k; dataIn = d;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic stepDirect(input logic [W-1:0] hi, input logic [W-1:0] lo,
                            input logic [W-1:0] sel);
    directEn = 1'b1; hiIn = hi; loIn = lo; colSelIn = sel;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic finish();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish();
    end
  end

  initial begin
    // R1: reset holds outputs at zero even with live inputs
    dataIn = 8'hFF; opCode = 2'b10; shiftAmt = 3'd2;
    repeat (3) @(negedge clk);
    check("R1", dataOut, 8'h00);
    checkBit("R1", selError, 1'b0);
    rstN = 1'b1;
    @(negedge clk);

    // table walk, R3..R6 with R7 on the error flag
    for (int v = 0; v < NV; v++) begin
      stepOp(VEC[v][20:19], VEC[v][18:16], VEC[v][15:8]);
      check(reqOf(VEC[v][20:19]), dataOut, VEC[v][7:0]);
      checkBit("R7", selError, 1'b0);
    end

    // exhaustive sweep of codes and distances against the bench model
    for (int p = 0; p < 4; p++) begin
      logic [W-1:0] pat;
      pat = (p == 0) ? 8'hB5 : (p == 1) ? 8'h81 : (p == 2) ? 8'h01 : 8'hFE;
      for (int op = 0; op < 4; op++) begin
        for (int k = 0; k < W; k++) begin
          stepOp(2'(op), 3'(k), pat);
          check(reqOf(2'(op)), dataOut, model(2'(op), k, pat));
          checkBit("R7", selError, 1'b0);
        end
      end
    end

    // R2: direct window reads bits j..j+7 of {hi, lo}
    stepDirect(8'hA5, 8'h3C, 8'h01);
    check("R2", dataOut, 8'h3C);
    stepDirect(8'hA5, 8'h3C, 8'h10);
    check("R2", dataOut, 8'h53);
    stepDirect(8'hA5, 8'h3C, 8'h80);
    check("R2", dataOut, 8'h4A);
    checkBit("R2", selError, 1'b0);

    // R9: shift controls and data word ignored in direct mode
    opCode = 2'b11; shiftAmt = 3'd5; dataIn = 8'h0F;
    stepDirect(8'hA5, 8'h3C, 8'h10);
    check("R9", dataOut, 8'h53);
    opCode = 2'b00; shiftAmt = 3'd2; dataIn = 8'hF0;
    stepDirect(8'hA5, 8'h3C, 8'h10);
    check("R9", dataOut, 8'h53);

    // R8: non-one-hot selects
    stepDirect(8'hFF, 8'hFF, 8'h00);
    check("R8", dataOut, 8'h00);
    checkBit("R8", selError, 1'b1);
    stepDirect(8'hFF, 8'hFF, 8'h11);
    check("R8", dataOut, 8'h00);
    checkBit("R8", selError, 1'b1);
    // recovery with a legal select
    stepDirect(8'hFF, 8'h00, 8'h08);
    check("R8", dataOut, 8'hE0);
    checkBit("R8", selError, 1'b0);

    // R9: result appears exactly one clock after capture
    directEn = 1'b0; opCode = 2'b00; shiftAmt = 3'd0; dataIn = 8'h3C;
    @(posedge clk); @(negedge clk);
    dataIn = 8'hC3;
    #1;
    check("R9", dataOut, 8'h3C);
    @(posedge clk); @(negedge clk);
    check("R9", dataOut, 8'hC3);

    // R1: asynchronous reset clears a live result
    rstN = 1'b0;
    #1;
    check("R1", dataOut, 8'h00);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    finish();
  end

endmodule